// File: doc/BRIEF.md
# Second-Chance Clock Victim Selector

This block chooses which physical frame to evict when the memory system needs room for a new page. Each frame has a one-bit "recently used" flag, and a circular hand points at the next frame to consider. Every access to a frame is reported on a reference input, and that input sets the frame's flag.

When a replacement is needed, the requester pulses a victim request. The block then steps the hand around the frames, one per clock. A frame whose flag is set gets a second chance: its flag is cleared and the hand moves on. The first frame found with a clear flag is returned as the victim, together with a one-cycle done strobe. The hand is then left on the frame just after the victim. References keep arriving while a sweep runs, and a reference always beats a clear that targets the same frame in the same cycle.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every frame's flag is 0, the hand is at frame 0, `victim_done` and `busy` are low, so the first request returns frame 0.
- R2: A cycle with `ref_valid` high sets the flag of frame `ref_frame` to 1.
- R3: A sweep starts at the current hand position and visits frames in increasing index order, wrapping from the last frame to frame 0.
- R4: A visited frame whose flag is 1 is not chosen; its flag is cleared to 0 and the hand moves to the next frame.
- R5: The first visited frame whose flag is 0 is returned on `victim_frame`.
- R6: After a victim is chosen the hand rests one frame past it, wrapping from frame 15 to frame 0.
- R7: If every flag is 1, the sweep clears all of them and returns the frame where it started, using N+1 visits for N frames.
- R8: One frame is visited per clock; `victim_done` is high for exactly one cycle, beginning k+1 cycles after the edge that accepts the request, where k is the number of frames skipped.
- R9: A reference to a frame in the same cycle that the sweep clears that frame leaves its flag at 1.
- R10: There are 16 frames; a `victim_request` while `busy` is high is ignored and neither restarts nor moves the sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A frame was accessed this cycle |
| ref_frame | input | 4 | Index of the accessed frame |
| victim_request | input | 1 | Ask for a replacement frame |
| victim_done | output | 1 | One-cycle strobe: `victim_frame` is valid |
| victim_frame | output | 4 | Index of the chosen frame |
| busy | output | 1 | A sweep is in progress |

## Verification
The hardest case to reach from the ports is a reference landing in the exact cycle the sweep clears that same frame, since the flag state is hidden and the collision window is one clock wide. The bench counts cycles from the accepting edge to place the reference on the second visit, then proves the flag survived by issuing a string of further requests until the hand comes back round and skips that frame. The ignored mid-sweep request and the all-flags-set wrap are reached the same way, by seeding flags through references and timing the stimulus from the accept edge.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  localparam int unsigned DEF_FRAMES = 16;

  typedef enum logic {
    SWEEP_IDLE = 1'b0,
    SWEEP_RUN  = 1'b1
  } sweep_state_e;

endpackage

// File: rtl/refbit_bank.sv
module refbit_bank #(
  parameter int unsigned N_FRAMES = clksel_pkg::DEF_FRAMES,
  parameter int unsigned IDX_W    = $clog2(N_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_valid,
  input  logic [IDX_W-1:0]    ref_frame,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_frame,
  output logic [N_FRAMES-1:0] ref_bits
);

  // one flag per frame; a reference outranks a clear aimed at the same frame
  for (genvar g = 0; g < N_FRAMES; g++) begin : g_flag
    logic hit_ref;
    logic hit_clr;
    assign hit_ref = ref_valid && (ref_frame == IDX_W'(g));
    assign hit_clr = clr_en && (clr_frame == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)       ref_bits[g] <= 1'b0;
      else if (hit_ref) ref_bits[g] <= 1'b1;
      else if (hit_clr) ref_bits[g] <= 1'b0;
    end
  end

  // history guard so $past never reaches into the reset window
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  logic same_target;
  assign same_target = ref_valid && clr_en && (ref_frame == clr_frame);

  assert_ref_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(ref_valid)) |-> ref_bits[$past(ref_frame)]);

  assert_skip_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(clr_en) && !$past(same_target)) |-> !ref_bits[$past(clr_frame)]);

  assert_ref_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(same_target)) |-> ref_bits[$past(clr_frame)]);

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl #(
  parameter int unsigned N_FRAMES = clksel_pkg::DEF_FRAMES,
  parameter int unsigned IDX_W    = $clog2(N_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                victim_request,
  input  logic [N_FRAMES-1:0] ref_bits,
  output logic                clr_en,
  output logic [IDX_W-1:0]    clr_frame,
  output logic                victim_done,
  output logic [IDX_W-1:0]    victim_frame,
  output logic                busy
);
  import clksel_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_FRAMES - 1);

  // circular successor of a frame index
  function automatic logic [IDX_W-1:0] hand_after(input logic [IDX_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  sweep_state_e       state_q;
  logic [IDX_W-1:0]   hand_q;
  logic               done_q;
  logic [IDX_W-1:0]   victim_q;

  // named internal events
  logic visit_ev;
  logic skip_ev;
  logic pick_ev;
  logic accept_ev;

  assign visit_ev  = (state_q == SWEEP_RUN);
  assign skip_ev   = visit_ev && ref_bits[hand_q];
  assign pick_ev   = visit_ev && !ref_bits[hand_q];
  assign accept_ev = (state_q == SWEEP_IDLE) && victim_request;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SWEEP_IDLE;
      hand_q   <= '0;
      done_q   <= 1'b0;
      victim_q <= '0;
    end else begin
      done_q <= pick_ev;
      unique case (state_q)
        SWEEP_IDLE: if (accept_ev) state_q <= SWEEP_RUN;
        SWEEP_RUN: begin
          hand_q <= hand_after(hand_q);
          if (pick_ev) begin
            victim_q <= hand_q;
            state_q  <= SWEEP_IDLE;
          end
        end
        default: state_q <= SWEEP_IDLE;
      endcase
    end
  end

  assign clr_en       = skip_ev;
  assign clr_frame    = hand_q;
  assign victim_done  = done_q;
  assign victim_frame = victim_q;
  assign busy         = visit_ev;

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    victim_done |=> !victim_done);

  assert_one_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (hand_q == hand_after($past(hand_q))));

  assert_hand_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (hand_q == $past(hand_q)));

  assert_hand_past_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    victim_done |-> (hand_q == hand_after(victim_frame)));

  assert_done_from_sweep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    victim_done |-> ($past(busy) && !busy));

  assert_req_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pick_ev && victim_request) |=> busy);

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int unsigned N_FRAMES = clksel_pkg::DEF_FRAMES,
  parameter int unsigned IDX_W    = $clog2(N_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_frame,
  input  logic             victim_request,
  output logic             victim_done,
  output logic [IDX_W-1:0] victim_frame,
  output logic             busy
);

  logic [N_FRAMES-1:0] ref_bits;
  logic                clr_en;
  logic [IDX_W-1:0]    clr_frame;

  refbit_bank #(.N_FRAMES(N_FRAMES), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_valid (ref_valid),
    .ref_frame (ref_frame),
    .clr_en    (clr_en),
    .clr_frame (clr_frame),
    .ref_bits  (ref_bits)
  );

  sweep_ctrl #(.N_FRAMES(N_FRAMES), .IDX_W(IDX_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .victim_request (victim_request),
    .ref_bits       (ref_bits),
    .clr_en         (clr_en),
    .clr_frame      (clr_frame),
    .victim_done    (victim_done),
    .victim_frame   (victim_frame),
    .busy           (busy)
  );

endmodule

// File: tb/test_clock_victim_sel.sv
`timescale 1ns/1ps
module test_clock_victim_sel;

  localparam int NF = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_valid = 1'b0;
  logic [3:0] ref_frame = '0;
  logic       victim_request = 1'b0;
  logic       victim_done;
  logic [3:0] victim_frame;
  logic       busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  int hand     = 0;   // bench model of the hand position

  always #2.5 clk = ~clk;

  clock_victim_sel i_clock_victim_sel (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
    .victim_request(victim_request), .victim_done(victim_done),
    .victim_frame(victim_frame), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int succ(input int p);
    return (p + 1) % NF;
  endfunction

  task automatic touch(input int f);
    ref_valid = 1'b1;
    ref_frame = 4'(f);
    @(posedge clk);
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  // issue one request; coll_cyc>0 references coll_frame just before visit edge coll_cyc;
  // extra_req re-raises the request before visit edges 1 and 2
  task automatic request(input int exp_frame, input int exp_lat, input string tag,
                         input int coll_frame, input int coll_cyc, input bit extra_req);
    int got_lat = -1;
    int got_frame = -1;
    victim_request = 1'b1;
    @(posedge clk);
    @(negedge clk);
    victim_request = 1'b0;
    for (int c = 1; c <= 40; c++) begin
      if (coll_cyc == c) begin
        ref_valid = 1'b1;
        ref_frame = 4'(coll_frame);
      end
      if (extra_req && c <= 2) victim_request = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ref_valid = 1'b0;
      victim_request = 1'b0;
      if (victim_done) begin
        got_lat = c;
        got_frame = int'(victim_frame);
        break;
      end
    end
    chk(got_frame == exp_frame, {tag, " victim"}, got_frame, exp_frame);
    chk(got_lat == exp_lat, {tag, " latency (R8)"}, got_lat, exp_lat);
    @(posedge clk);
    @(negedge clk);
    chk(!victim_done, "R8 strobe one cycle", int'(victim_done), 0);
    hand = succ(exp_frame);
  endtask

  task automatic t_reset;
    chk(!victim_done && !busy, "R1 idle outputs after reset", int'({victim_done, busy}), 0);
    request(0, 1, "R1 first victim", 0, 0, 1'b0);
  endtask

  task automatic t_skip;
    // flags on 1,2,3 (R2); hand at 1 -> skips three, picks 4 (R3 R4 R5)
    touch(1); touch(2); touch(3);
    request(4, 4, "R4 R5 skip set frames", 0, 0, 1'b0);
    request(5, 1, "R6 hand past victim", 0, 0, 1'b0);
  endtask

  task automatic t_wrap;
    for (int f = 6; f < NF; f++) request(f, 1, "R3 ascending order", 0, 0, 1'b0);
    request(0, 1, "R6 wrap 15 to 0", 0, 0, 1'b0);
    request(1, 1, "R4 skipped flag cleared", 0, 0, 1'b0);
  endtask

  task automatic t_all_set;
    for (int f = 0; f < NF; f++) touch(f);
    request(2, NF + 1, "R7 all set returns start", 0, 0, 1'b0);
    request(3, 1, "R7 all flags cleared", 0, 0, 1'b0);
  endtask

  task automatic t_collision;
    // hand at 4; flags 4,5,6; visit of frame 5 happens on edge 2
    touch(4); touch(5); touch(6);
    request(7, 4, "R9 sweep with collision", 5, 2, 1'b0);
    for (int f = 8; f < NF; f++) request(f, 1, "R9 walk", 0, 0, 1'b0);
    for (int f = 0; f <= 4; f++) request(f, 1, "R9 walk", 0, 0, 1'b0);
    request(6, 2, "R9 reference kept frame 5", 0, 0, 1'b0);
  endtask

  task automatic t_ignore;
    int extra = 0;
    // hand at 7; flags 7..10 -> victim 11 after 5 visits
    touch(7); touch(8); touch(9); touch(10);
    request(11, 5, "R10 request during sweep", 0, 0, 1'b1);
    for (int c = 0; c < 10; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (victim_done || busy) extra++;
    end
    chk(extra == 0, "R10 no second sweep", extra, 0);
    request(12, 1, "R10 hand undisturbed", 0, 0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    t_reset();
    t_skip();
    t_wrap();
    t_all_set();
    t_collision();
    t_ignore();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule